// File: doc/BRIEF.md
# Slot takeover controller

This block sits on an add-in processor card and takes the system bus away from the motherboard CPU. It lowers a slot request and waits for the CPU grant to come back low. It then lowers its ownership line while the request is still low, and only after that does it release the request. The CPU grant going back high after the request is released is expected, and the block does not treat it as losing the bus. A board with no CPU fitted echoes the request straight back as the grant, and the handshake also works in that case.

Once it owns the bus, the block acts as the system arbiter. It grants system bus requests whenever the card is not in the middle of a bus cycle. It holds each grant until the requester acknowledges it, and it waits for the acknowledge to clear before it grants again. The system grant pin is driven only while ownership is held; at all other times its output enable is low.

A release input gives the bus back in an orderly way. If no grant is in progress, the block drops ownership at once. If a grant is in progress, it first lets that grant finish, acknowledge and all. If the CPU grant never arrives, a timeout drops the request and raises an error flag.

The takeover state machine has five states:

| State | Meaning |
|---|---|
| IDLE | No request, no ownership. |
| REQUEST | Request low; counting towards the timeout. |
| SEIZE | Request and ownership both low, for one cycle. |
| OWNED | Ownership low, request released. |
| FAULT | Timeout; error flag high. |

Its transitions are:

- IDLE→REQUEST when takeover is enabled.
- REQUEST→SEIZE when the grant is seen.
- REQUEST→FAULT when the count expires.
- SEIZE→OWNED always.
- OWNED→IDLE on release with no grant in progress.
- FAULT→IDLE when takeover is disabled.

The system arbiter has three states:

| State | Meaning |
|---|---|
| ARB_IDLE | No grant in progress. |
| ARB_GRANT | Grant driven low, waiting for the acknowledge. |
| ARB_DRAIN | Grant negated, waiting for the acknowledge to clear. |

Its transitions are:

- ARB_IDLE→ARB_GRANT on a request while the card owns the bus, is not busy and is not releasing.
- ARB_GRANT→ARB_DRAIN when the acknowledge is seen.
- ARB_DRAIN→ARB_IDLE when the acknowledge clears.

Top module: `slot_takeover_ctrl`

## Requirements
- R1: After reset, slot_req_n=1, own_n=1, sys_bg_oe=0, sys_bg_n=1 and timeout_err=0.
- R2: When takeover_en is high in the idle state, slot_req_n goes low one clock later.
- R3: The CPU grant is seen after two synchronizer stages. On the next clock own_n goes low while slot_req_n is still low, and slot_req_n goes high one clock after that. own_n is never low at the same time as slot_req_n is low except in that single cycle.
- R4: Once own_n is low, the CPU grant going high has no effect; only a release ends ownership.
- R5: sys_bg_oe is 1 exactly while own_n is 0, and sys_bg_n is 1 whenever sys_bg_oe is 0.
- R6: The takeover completes when cpu_gnt_n follows slot_req_n with no delay.
- R7: While the card owns the bus, a low sys_br_n produces sys_bg_n=0 only while local_busy=0. No new grant starts while release_req=1.
- R8: sys_bg_n stays 0 until the synchronized sys_bgack_n is 0, then returns to 1. No new grant is issued until sys_bgack_n has returned to 1.
- R9: On release_req, own_n goes high (and sys_bg_oe low) only once no grant or acknowledge is in progress.
- R10: If no grant arrives, slot_req_n is held low for exactly TIMEOUT_CYCLES clocks (default 1024). It then goes high and timeout_err goes to 1. The error stays until takeover_en is low, and the block then returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| takeover_en | input | 1 | Start a takeover (synchronous, active high) |
| release_req | input | 1 | Give the bus back (synchronous, active high) |
| local_busy | input | 1 | Card is mid-cycle; hold off system grants |
| slot_req_n | output | 1 | Slot bus request to the CPU, active low |
| cpu_gnt_n | input | 1 | CPU grant, asynchronous, active low |
| own_n | output | 1 | Card owns the system, active low |
| sys_br_n | input | 1 | System bus request, asynchronous, active low |
| sys_bgack_n | input | 1 | System grant acknowledge, asynchronous, active low |
| sys_bg_n | output | 1 | System bus grant value, active low |
| sys_bg_oe | output | 1 | Output enable for sys_bg_n (0 means high impedance) |
| timeout_err | output | 1 | The CPU grant never arrived |

## Verification
A corrupted takeover state shows at the ports within one clock, because every output is decoded straight from the state register. It appears as an out-of-order change of the request and ownership lines, for example the request released before ownership is taken, or ownership dropped when the CPU grant goes inactive. A wrong arbiter state shows up in one of three ways: a grant while the card is busy, a grant that disappears before its acknowledge, or a second grant while the acknowledge is still low. All three appear on sys_bg_n within the three-clock input latency. The bench compares the ordered sequence of every output change against the sequence it expects. A spurious or missing transition is therefore caught even when the final state happens to be correct.

// File: rtl/slot_takeover_pkg.sv
package slot_takeover_pkg;

    typedef enum logic [2:0] {
        TK_IDLE,
        TK_REQUEST,
        TK_SEIZE,
        TK_OWNED,
        TK_FAULT
    } tk_state_e;

    typedef enum logic [1:0] {
        ARB_IDLE,
        ARB_GRANT,
        ARB_DRAIN
    } arb_state_e;

endpackage

// File: rtl/slot_sync.sv
module slot_sync #(
    parameter int              WIDTH     = 1,
    parameter int              STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                chain_q[i] <= RESET_VAL;
            end
        end else begin
            for (int i = STAGES - 1; i > 0; i--) begin
                chain_q[i] <= chain_q[i-1];
            end
            chain_q[0] <= async_i;
        end
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/slot_takeover_fsm.sv
module slot_takeover_fsm
    import slot_takeover_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic takeover_en_i,
    input  logic release_i,
    input  logic cpu_gnt_i,
    input  logic arb_idle_i,
    output logic slot_req_o,
    output logic own_o,
    output logic owner_o,
    output logic fault_o
);

    localparam int CNT_W = (TIMEOUT_CYCLES > 2) ? $clog2(TIMEOUT_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYCLES - 1);

    tk_state_e        state_q, state_d;
    logic [CNT_W-1:0] wait_cnt_q;

    // State register and request timer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= TK_IDLE;
            wait_cnt_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == TK_REQUEST) begin
                wait_cnt_q <= wait_cnt_q + 1'b1;
            end else begin
                wait_cnt_q <= '0;
            end
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TK_IDLE: begin
                if (takeover_en_i) state_d = TK_REQUEST;
            end
            TK_REQUEST: begin
                if (cpu_gnt_i)                    state_d = TK_SEIZE;
                else if (wait_cnt_q == CNT_LAST)  state_d = TK_FAULT;
            end
            TK_SEIZE: begin
                state_d = TK_OWNED;
            end
            TK_OWNED: begin
                if (release_i && arb_idle_i) state_d = TK_IDLE;
            end
            TK_FAULT: begin
                if (!takeover_en_i) state_d = TK_IDLE;
            end
            default: state_d = TK_IDLE;
        endcase
    end

    // Outputs (Moore)
    always_comb begin
        slot_req_o = 1'b0;
        own_o      = 1'b0;
        owner_o    = 1'b0;
        fault_o    = 1'b0;
        unique case (state_q)
            TK_IDLE: ;
            TK_REQUEST: begin
                slot_req_o = 1'b1;
            end
            TK_SEIZE: begin
                slot_req_o = 1'b1;
                own_o      = 1'b1;
            end
            TK_OWNED: begin
                own_o   = 1'b1;
                owner_o = 1'b1;
            end
            TK_FAULT: begin
                fault_o = 1'b1;
            end
            default: ;
        endcase
    end

    // R3: the request is only dropped once ownership is held (or on timeout)
    p_own_before_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(slot_req_o) |-> (own_o || fault_o));

    // R4: ownership persists while no release is asked for
    p_own_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (own_o && !release_i) |=> own_o);

    // R9: ownership only ends when no grant was in progress
    p_release_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(own_o) |-> $past(arb_idle_i));

endmodule

// File: rtl/slot_sys_arbiter.sv
module slot_sys_arbiter
    import slot_takeover_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic owner_i,
    input  logic hold_i,
    input  logic busy_i,
    input  logic br_i,
    input  logic ack_i,
    output logic gnt_o,
    output logic idle_o
);

    arb_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ARB_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_IDLE: begin
                if (owner_i && br_i && !busy_i && !hold_i) state_d = ARB_GRANT;
            end
            ARB_GRANT: begin
                if (ack_i) state_d = ARB_DRAIN;
            end
            ARB_DRAIN: begin
                if (!ack_i) state_d = ARB_IDLE;
            end
            default: state_d = ARB_IDLE;
        endcase
    end

    always_comb begin
        gnt_o  = 1'b0;
        idle_o = 1'b0;
        unique case (state_q)
            ARB_IDLE:  idle_o = 1'b1;
            ARB_GRANT: gnt_o  = 1'b1;
            ARB_DRAIN: ;
            default:   idle_o = 1'b1;
        endcase
    end

    // R7: a grant never starts while the card is busy or not the owner
    p_grant_when_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gnt_o) |-> (!$past(busy_i) && owner_i));

    // R8: grant held until acknowledged
    p_grant_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o && !ack_i) |=> gnt_o);

    // R8: grant only removed after an acknowledge
    p_grant_drop_on_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gnt_o) |-> $past(ack_i));

    // R5: no grant without ownership
    p_grant_needs_owner_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !owner_i |-> !gnt_o);

endmodule

// File: rtl/slot_takeover_ctrl.sv
module slot_takeover_ctrl
    import slot_takeover_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 1024,
    parameter int SYNC_STAGES    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic takeover_en,
    input  logic release_req,
    input  logic local_busy,
    output logic slot_req_n,
    input  logic cpu_gnt_n,
    output logic own_n,
    input  logic sys_br_n,
    input  logic sys_bgack_n,
    output logic sys_bg_n,
    output logic sys_bg_oe,
    output logic timeout_err
);

    localparam int ASYNC_W = 3;

    logic [ASYNC_W-1:0] async_raw;
    logic [ASYNC_W-1:0] async_sync;
    logic cpu_gnt_s, sys_br_s, sys_ack_s;
    logic slot_req, own, owner, fault;
    logic arb_gnt, arb_idle;

    assign async_raw = {cpu_gnt_n, sys_br_n, sys_bgack_n};

    slot_sync #(
        .WIDTH     (ASYNC_W),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL ('1)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (async_raw),
        .sync_o  (async_sync)
    );

    assign cpu_gnt_s = ~async_sync[2];
    assign sys_br_s  = ~async_sync[1];
    assign sys_ack_s = ~async_sync[0];

    slot_takeover_fsm #(
        .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .takeover_en_i (takeover_en),
        .release_i     (release_req),
        .cpu_gnt_i     (cpu_gnt_s),
        .arb_idle_i    (arb_idle),
        .slot_req_o    (slot_req),
        .own_o         (own),
        .owner_o       (owner),
        .fault_o       (fault)
    );

    slot_sys_arbiter u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .owner_i (owner),
        .hold_i  (release_req),
        .busy_i  (local_busy),
        .br_i    (sys_br_s),
        .ack_i   (sys_ack_s),
        .gnt_o   (arb_gnt),
        .idle_o  (arb_idle)
    );

    assign slot_req_n  = ~slot_req;
    assign own_n       = ~own;
    assign sys_bg_oe   = own;
    assign sys_bg_n    = ~arb_gnt;
    assign timeout_err = fault;

    // R5: the grant pin shows inactive whenever it is not driven
    p_undriven_inactive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !sys_bg_oe |-> sys_bg_n);

    // R10: an error leaves neither request nor ownership asserted
    p_fault_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err |-> (slot_req_n && own_n));

endmodule

// File: tb/slot_takeover_ctrl_tb.sv
module slot_takeover_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int TMO        = 1024;

    // Output vector: {slot_req_n, own_n, sys_bg_oe, sys_bg_n, timeout_err}
    localparam logic [4:0] V_IDLE  = 5'b11010;
    localparam logic [4:0] V_REQ   = 5'b01010;
    localparam logic [4:0] V_SEIZE = 5'b00110;
    localparam logic [4:0] V_OWN   = 5'b10110;
    localparam logic [4:0] V_GNT   = 5'b10100;
    localparam logic [4:0] V_FAULT = 5'b11011;

    typedef struct {
        logic [4:0] v;
        string      tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic takeover_en = 1'b0;
    logic release_req = 1'b0;
    logic local_busy  = 1'b0;
    logic echo_mode   = 1'b1;
    logic cpu_gnt_drv = 1'b1;
    logic sys_br_n    = 1'b1;
    logic sys_bgack_n = 1'b1;
    logic slot_req_n, own_n, sys_bg_n, sys_bg_oe, timeout_err;
    logic cpu_gnt_n;

    int total = 0;
    int bad   = 0;
    bit mon_on = 1'b0;
    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    assign cpu_gnt_n = echo_mode ? slot_req_n : cpu_gnt_drv;

    slot_takeover_ctrl #(.TIMEOUT_CYCLES(TMO)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .takeover_en (takeover_en),
        .release_req (release_req),
        .local_busy  (local_busy),
        .slot_req_n  (slot_req_n),
        .cpu_gnt_n   (cpu_gnt_n),
        .own_n       (own_n),
        .sys_br_n    (sys_br_n),
        .sys_bgack_n (sys_bgack_n),
        .sys_bg_n    (sys_bg_n),
        .sys_bg_oe   (sys_bg_oe),
        .timeout_err (timeout_err)
    );

    function automatic logic [4:0] outs();
        return {slot_req_n, own_n, sys_bg_oe, sys_bg_n, timeout_err};
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic expect_vec(input logic [4:0] v, input string tag);
        exp_t e;
        e.v   = v;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: every change of the output vector must match the next expected item
    initial begin
        logic [4:0] prev;
        prev = V_IDLE;
        forever begin
            @(negedge clk);
            if (mon_on && outs() != prev) begin
                total++;
                if (exp_q.size() == 0) begin
                    bad++;
                    $display("FAIL unexpected change act=%b exp=%b", outs(), prev);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    if (e.v != outs()) begin
                        bad++;
                        $display("FAIL %s act=%b exp=%b", e.tag, outs(), e.v);
                    end
                end
                prev = outs();
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n;
        cycles(3);
        rst_n = 1'b1;
        cycles(1);
        chk("R1 reset outputs", int'(outs()), int'(V_IDLE));
        mon_on = 1'b1;

        // Takeover with the grant echoed at once
        expect_vec(V_REQ,   "R2 request");
        expect_vec(V_SEIZE, "R6 echo seize, R3 own while request low");
        expect_vec(V_OWN,   "R3 request released after own");
        takeover_en = 1'b1;
        cycles(1);
        chk("R2 request one clock later", int'(slot_req_n), 0);
        takeover_en = 1'b0;
        cycles(20);
        chk("R4 own held with cpu grant inactive", int'(own_n), 0);
        chk("R4 cpu grant inactive", int'(cpu_gnt_n), 1);

        // Busy card holds off a system grant
        local_busy = 1'b1;
        sys_br_n   = 1'b0;
        cycles(15);
        chk("R7 no grant while busy", int'(sys_bg_n), 1);
        expect_vec(V_GNT, "R7 grant once free");
        local_busy = 1'b0;
        cycles(4);
        chk("R7 grant after busy clears", int'(sys_bg_n), 0);

        // Acknowledge, and no new grant while it is held
        expect_vec(V_OWN, "R8 grant negated on ack");
        sys_bgack_n = 1'b0;
        cycles(12);
        chk("R8 no regrant while ack low", int'(sys_bg_n), 1);
        expect_vec(V_GNT, "R8 regrant after ack clears");
        sys_bgack_n = 1'b1;
        cycles(6);
        expect_vec(V_OWN, "R8 second grant negated");
        sys_bgack_n = 1'b0;
        sys_br_n    = 1'b1;
        cycles(6);
        sys_bgack_n = 1'b1;
        cycles(6);

        // Release with a grant in progress
        expect_vec(V_GNT, "R7 grant before release");
        sys_br_n = 1'b0;
        cycles(6);
        release_req = 1'b1;
        cycles(10);
        chk("R9 own held while grant outstanding", int'(own_n), 0);
        expect_vec(V_OWN,  "R9 grant acknowledged");
        expect_vec(V_IDLE, "R9 release completes");
        sys_bgack_n = 1'b0;
        sys_br_n    = 1'b1;
        cycles(10);
        chk("R9 own held while ack low", int'(own_n), 0);
        sys_bgack_n = 1'b1;
        cycles(6);
        release_req = 1'b0;
        chk("R9 own released", int'(own_n), 1);
        chk("R5 grant pin undriven after release", int'(sys_bg_oe), 0);

        // Timeout when no grant arrives
        echo_mode   = 1'b0;
        cpu_gnt_drv = 1'b1;
        expect_vec(V_REQ,   "R10 request");
        expect_vec(V_FAULT, "R10 timeout");
        takeover_en = 1'b1;
        n = 0;
        while (1) begin
            @(negedge clk);
            if (timeout_err) break;
            if (!slot_req_n) n++;
        end
        chk("R10 request length", n, TMO);
        cycles(10);
        chk("R10 error sticky while enabled", int'(timeout_err), 1);
        expect_vec(V_IDLE, "R10 back to idle");
        takeover_en = 1'b0;
        cycles(3);
        chk("R10 error cleared", int'(timeout_err), 0);

        // Slow manual grant
        expect_vec(V_REQ,   "R2 request (slow grant)");
        expect_vec(V_SEIZE, "R3 seize (slow grant)");
        expect_vec(V_OWN,   "R3 owned (slow grant)");
        takeover_en = 1'b1;
        cycles(30);
        chk("R5 grant pin undriven before own", int'(sys_bg_oe), 0);
        chk("R3 no own before grant", int'(own_n), 1);
        cpu_gnt_drv = 1'b0;
        cycles(10);
        cpu_gnt_drv = 1'b1;
        takeover_en = 1'b0;
        cycles(10);
        chk("R4 own held after cpu grant drops", int'(own_n), 0);
        chk("R5 grant pin driven while owned", int'(sys_bg_oe), 1);

        cycles(5);
        chk("R3 all expected changes seen", exp_q.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule